// File: doc/BRIEF.md
# Timestamped Event I/O Target

This block is one endpoint on a shared command bus for time-stamped input and output events. A single initiator drives a two-bit command together with a channel select, an output timestamp, output data, a sub-address and an input deadline. The target answers through small status vectors.

A write command queues an output event in a local FIFO. The event carries its timestamp, data, sub-address and 16-bit channel. Each queued event leaves on an emission strobe once the free-running time counter input reaches its timestamp. A write whose time has already come is refused as an underflow. A write that finds the queue full stalls with a wait flag until a slot opens. A space query returns a count of free slots that never overstates the truth.

Input events come in through a capture strobe. Each one is stamped with the current counter value and held in an input FIFO. A read command returns the oldest captured event. It can also report a timeout once the counter passes the deadline given with the read, or report that captured events were lost.

Top module: `tsio_target`

## Requirements
- R1: The command field is decoded as 0 = no operation, 1 = write, 2 = read, 3 = buffer-space query. A no-operation cycle changes no status, queues nothing and emits nothing.
- R2: Bits 23:16 of the channel select (the destination) are ignored. Bits 15:0 travel with the event and appear on the emitted channel output.
- R3: An accepted write whose timestamp is strictly greater than the time counter is queued. In the cycle after the write, all bits of the output status are 0.
- R4: A write whose timestamp is less than or equal to the time counter sets output status bit 1 (underflow) and is dropped. The bit stays set until the next accepted write.
- R5: A write that finds the output FIFO full sets output status bit 0 (wait). That bit stays high until a slot frees, at which point the held write is queued and the bit clears. Write commands issued while the bit is high are ignored.
- R6: Queued events are emitted in FIFO order. Each emission is a one-cycle strobe, in the cycle after the time counter is at or past the event's timestamp, and carries the event's timestamp, data, sub-address and channel.
- R7: A buffer-space query raises the valid strobe for exactly the next cycle. The accompanying 16-bit count equals the free output slots when no write is stalled, is 0 while a write is stalled, and never exceeds the true free count.
- R8: In the cycle after a read command, input status is 4'b0100 (bit 2, wait for status). Bit 2 stays high until the read completes. Read commands issued during that time are ignored.
- R9: A read that finds a captured event completes with input status 0. The event's 32-bit data and 64-bit capture time then appear on the input outputs and are held until the next read completes with an event.
- R10: A read with no captured event completes when the time counter is at or past the read deadline, with input status 4'b0001 (bit 0, timeout).
- R11: A capture that arrives while the input FIFO is full is lost and sets a sticky overflow flag. The next read completes with input status 4'b0010 (bit 1 only) without consuming an event, and clears the flag. Input status bits 0 and 1 are never both set.
- R12: The destination-unreachable bits, output status bit 2 and input status bit 3, are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_ts | input | 64 | Free-running time counter |
| cmd | input | 2 | Bus command |
| chan_sel | input | 24 | Destination (23:16) and channel (15:0) |
| o_ts | input | 64 | Output event timestamp |
| o_data | input | ODW | Output event data |
| o_addr | input | 8 | Output event sub-address |
| o_status | output | 3 | bit0 wait, bit1 underflow, bit2 unreachable |
| space_valid | output | 1 | Buffer-space answer strobe |
| space | output | 16 | Pessimistic free output slot count |
| i_timeout | input | 64 | Read deadline timestamp |
| i_data | output | IDW | Data of last returned input event |
| i_ts | output | 64 | Capture time of last returned input event |
| i_status | output | 4 | bit0 timeout, bit1 overflow, bit2 wait, bit3 unreachable |
| cap_valid | input | 1 | Input capture strobe |
| cap_data | input | IDW | Captured input data |
| emit_valid | output | 1 | Output event emission strobe |
| emit_ts | output | 64 | Emitted event timestamp |
| emit_data | output | ODW | Emitted event data |
| emit_addr | output | 8 | Emitted event sub-address |
| emit_chan | output | 16 | Emitted event channel |

## Verification
The bench writes with a timestamp equal to the counter, because a design that compared with strict less-than would queue and later emit an event that should have been refused. It fills the output queue, stalls a further write and issues a stray write during the stall. A design that lost the held write, accepted the stray one or reported a space count above zero would then emit the wrong sequence or count. On the input side it overflows the capture FIFO, checks that the next read reports overflow alone without consuming data and that the read after it returns the oldest event. It also holds a read just short of its deadline to catch a timeout raised one cycle early.

// File: rtl/tsio_pkg.sv
package tsio_pkg;
   typedef enum logic [1:0] {
      CMD_NOP   = 2'd0,
      CMD_WRITE = 2'd1,
      CMD_READ  = 2'd2,
      CMD_SPACE = 2'd3
   } tsio_cmd_e;

   localparam int TS_W    = 64;
   localparam int CHAN_W  = 16;
   localparam int DEST_W  = 8;
   localparam int SEL_W   = CHAN_W + DEST_W;
   localparam int ADDR_W  = 8;
   localparam int SPACE_W = 16;

   localparam int OST_WAIT    = 0;
   localparam int OST_UNDER   = 1;
   localparam int OST_UNREACH = 2;

   localparam int IST_TIMEOUT = 0;
   localparam int IST_OVER    = 1;
   localparam int IST_WAIT    = 2;
   localparam int IST_UNREACH = 3;
endpackage

// File: rtl/tsio_fifo.sv
module tsio_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("tsio_fifo: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("tsio_fifo: W must be positive");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nxt, rp_nxt;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nxt = wp + 1'b1;
         assign rp_nxt = rp + 1'b1;
      end else begin : g_mod
         assign wp_nxt = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nxt = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp_nxt;
         if (do_pop)  rp <= rp_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/tsio_out_path.sv
module tsio_out_path
   import tsio_pkg::*;
#(
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int EW   = TS_W + DW + ADDR_W + CHAN_W,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TS_W-1:0]    now_ts,
   input  logic [1:0]         cmd,
   input  logic [CHAN_W-1:0]  chan,
   input  logic [TS_W-1:0]    o_ts,
   input  logic [DW-1:0]      o_data,
   input  logic [ADDR_W-1:0]  o_addr,
   output logic [2:0]         o_status,
   output logic               space_valid,
   output logic [SPACE_W-1:0] space,
   output logic               emit_valid,
   output logic [TS_W-1:0]    emit_ts,
   output logic [DW-1:0]      emit_data,
   output logic [ADDR_W-1:0]  emit_addr,
   output logic [CHAN_W-1:0]  emit_chan
);
   logic          wait_q, under_q;
   logic [EW-1:0] held_q, new_word, fifo_in, head;
   logic          accept_new, late, push, pop, full, empty;
   logic [CW-1:0] count, free_now;
   logic [SPACE_W-1:0] space_d;
   logic [TS_W-1:0]    head_ts;

   assign accept_new = (cmd == CMD_WRITE) && !wait_q;
   assign late       = (o_ts <= now_ts);
   assign new_word   = {o_ts, o_data, o_addr, chan};
   assign head_ts    = head[EW-1 -: TS_W];
   assign pop        = !empty && (head_ts <= now_ts);
   assign push       = (wait_q && !full) || (accept_new && !late && !full);
   assign fifo_in    = wait_q ? held_q : new_word;
   assign free_now   = CW'(DEPTH) - count;

   generate
      if (CW <= SPACE_W) begin : g_space_direct
         assign space_d = wait_q ? '0 : SPACE_W'(free_now);
      end else begin : g_space_sat
         assign space_d = wait_q ? '0 :
                          (free_now > CW'({SPACE_W{1'b1}})) ? {SPACE_W{1'b1}}
                                                             : SPACE_W'(free_now);
      end
   endgenerate

   tsio_fifo #(.W(EW), .DEPTH(DEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .wdata (fifo_in),
      .pop   (pop),
      .rdata (head),
      .full  (full),
      .empty (empty),
      .count (count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_q      <= 1'b0;
         under_q     <= 1'b0;
         held_q      <= '0;
         space_valid <= 1'b0;
         space       <= '0;
         emit_valid  <= 1'b0;
         emit_ts     <= '0;
         emit_data   <= '0;
         emit_addr   <= '0;
         emit_chan   <= '0;
      end else begin
         if (accept_new) begin
            under_q <= late;
            if (!late && full) begin
               wait_q <= 1'b1;
               held_q <= new_word;
            end
         end else if (wait_q && !full) begin
            wait_q <= 1'b0;
         end
         space_valid <= (cmd == CMD_SPACE);
         if (cmd == CMD_SPACE) space <= space_d;
         emit_valid <= pop;
         if (pop) begin
            emit_ts   <= head_ts;
            emit_data <= head[EW-TS_W-1 -: DW];
            emit_addr <= head[CHAN_W +: ADDR_W];
            emit_chan <= head[CHAN_W-1:0];
         end
      end
   end

   assign o_status = {1'b0, under_q, wait_q};

   assert_space_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      space_valid |-> (int'(space) <= DEPTH - int'(count)));
   assert_late_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_WRITE && !o_status[OST_WAIT] && o_ts <= now_ts) |=> o_status[OST_UNDER]);
   assert_emit_due_R6: assert property (@(posedge clk) disable iff (!rst_n)
      emit_valid |-> (emit_ts <= $past(now_ts)));
   assert_out_unreach_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !o_status[OST_UNREACH]);
endmodule

// File: rtl/tsio_in_path.sv
module tsio_in_path
   import tsio_pkg::*;
#(
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int EW   = TS_W + DW,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TS_W-1:0] now_ts,
   input  logic [1:0]      cmd,
   input  logic [TS_W-1:0] i_timeout,
   input  logic            cap_valid,
   input  logic [DW-1:0]   cap_data,
   output logic [3:0]      i_status,
   output logic [DW-1:0]   i_data,
   output logic [TS_W-1:0] i_ts
);
   logic            busy_q, ovf_q;
   logic [TS_W-1:0] dl_q;
   logic [3:0]      st_q;
   logic            start, pop, full, empty;
   logic [EW-1:0]   head;
   logic [CW-1:0]   count;
   logic            unused_count;

   assign unused_count = ^count;
   assign start = (cmd == CMD_READ) && !busy_q;
   assign pop   = busy_q && !ovf_q && !empty;

   tsio_fifo #(.W(EW), .DEPTH(DEPTH)) u_capture (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (cap_valid),
      .wdata ({now_ts, cap_data}),
      .pop   (pop),
      .rdata (head),
      .full  (full),
      .empty (empty),
      .count (count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ovf_q  <= 1'b0;
         dl_q   <= '0;
         st_q   <= '0;
         i_data <= '0;
         i_ts   <= '0;
      end else begin
         if (cap_valid && full)      ovf_q <= 1'b1;
         else if (busy_q && ovf_q)   ovf_q <= 1'b0;

         if (start) begin
            busy_q <= 1'b1;
            dl_q   <= i_timeout;
            st_q   <= 4'b0100;
         end else if (busy_q) begin
            if (ovf_q) begin
               busy_q <= 1'b0;
               st_q   <= 4'b0010;
            end else if (!empty) begin
               busy_q <= 1'b0;
               st_q   <= 4'b0000;
               i_data <= head[DW-1:0];
               i_ts   <= head[EW-1 -: TS_W];
            end else if (now_ts >= dl_q) begin
               busy_q <= 1'b0;
               st_q   <= 4'b0001;
            end
         end
      end
   end

   assign i_status = st_q;

   assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(i_status[IST_TIMEOUT] && i_status[IST_OVER]));
   assert_wait_from_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(i_status[IST_WAIT]) |-> ($past(cmd) == CMD_READ));
   assert_timeout_due_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(i_status[IST_TIMEOUT]) |-> ($past(now_ts) >= dl_q));
   assert_in_unreach_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !i_status[IST_UNREACH]);
endmodule

// File: rtl/tsio_target.sv
module tsio_target
   import tsio_pkg::*;
#(
   parameter int ODW       = 32,
   parameter int IDW       = 32,
   parameter int OUT_DEPTH = 4,
   parameter int IN_DEPTH  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TS_W-1:0]    now_ts,
   input  logic [1:0]         cmd,
   input  logic [SEL_W-1:0]   chan_sel,
   input  logic [TS_W-1:0]    o_ts,
   input  logic [ODW-1:0]     o_data,
   input  logic [ADDR_W-1:0]  o_addr,
   output logic [2:0]         o_status,
   output logic               space_valid,
   output logic [SPACE_W-1:0] space,
   input  logic [TS_W-1:0]    i_timeout,
   output logic [IDW-1:0]     i_data,
   output logic [TS_W-1:0]    i_ts,
   output logic [3:0]         i_status,
   input  logic               cap_valid,
   input  logic [IDW-1:0]     cap_data,
   output logic               emit_valid,
   output logic [TS_W-1:0]    emit_ts,
   output logic [ODW-1:0]     emit_data,
   output logic [ADDR_W-1:0]  emit_addr,
   output logic [CHAN_W-1:0]  emit_chan
);
   generate
      if (ODW < 1 || IDW < 1) begin : g_bad_width
         $error("tsio_target: data widths must be positive");
      end
   endgenerate

   logic unused_dest;
   assign unused_dest = ^chan_sel[SEL_W-1:CHAN_W];

   tsio_out_path #(.DW(ODW), .DEPTH(OUT_DEPTH)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .now_ts      (now_ts),
      .cmd         (cmd),
      .chan        (chan_sel[CHAN_W-1:0]),
      .o_ts        (o_ts),
      .o_data      (o_data),
      .o_addr      (o_addr),
      .o_status    (o_status),
      .space_valid (space_valid),
      .space       (space),
      .emit_valid  (emit_valid),
      .emit_ts     (emit_ts),
      .emit_data   (emit_data),
      .emit_addr   (emit_addr),
      .emit_chan   (emit_chan)
   );

   tsio_in_path #(.DW(IDW), .DEPTH(IN_DEPTH)) u_in (
      .clk       (clk),
      .rst_n     (rst_n),
      .now_ts    (now_ts),
      .cmd       (cmd),
      .i_timeout (i_timeout),
      .cap_valid (cap_valid),
      .cap_data  (cap_data),
      .i_status  (i_status),
      .i_data    (i_data),
      .i_ts      (i_ts)
   );
endmodule

// File: tb/tsio_target_tb.sv
`timescale 1ns/1ps
module tsio_target_tb;
   import tsio_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] now_ts = 64'd100;
   logic [1:0]  cmd = CMD_NOP;
   logic [23:0] chan_sel = '0;
   logic [63:0] o_ts = '0;
   logic [31:0] o_data = '0;
   logic [7:0]  o_addr = '0;
   logic [2:0]  o_status;
   logic        space_valid;
   logic [15:0] space;
   logic [63:0] i_timeout = '0;
   logic [31:0] i_data;
   logic [63:0] i_ts;
   logic [3:0]  i_status;
   logic        cap_valid = 1'b0;
   logic [31:0] cap_data = '0;
   logic        emit_valid;
   logic [63:0] emit_ts;
   logic [31:0] emit_data;
   logic [7:0]  emit_addr;
   logic [15:0] emit_chan;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [119:0] exp_emit [$];
   logic [95:0]  exp_read [$];

   always #2.5 clk = ~clk;

   tsio_target u_dut (
      .clk(clk), .rst_n(rst_n), .now_ts(now_ts), .cmd(cmd), .chan_sel(chan_sel),
      .o_ts(o_ts), .o_data(o_data), .o_addr(o_addr), .o_status(o_status),
      .space_valid(space_valid), .space(space), .i_timeout(i_timeout),
      .i_data(i_data), .i_ts(i_ts), .i_status(i_status), .cap_valid(cap_valid),
      .cap_data(cap_data), .emit_valid(emit_valid), .emit_ts(emit_ts),
      .emit_data(emit_data), .emit_addr(emit_addr), .emit_chan(emit_chan)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_unreach();
      chk(!o_status[2] && !i_status[3], "R12", {o_status, i_status}, 0);
   endtask

   task automatic do_write(input logic [63:0] ts, input logic [31:0] d,
                           input logic [7:0] a, input logic [23:0] sel, input bit expect_q);
      o_ts = ts; chan_sel = sel; tick();
      o_data = d; o_addr = a; cmd = CMD_WRITE; tick();
      cmd = CMD_NOP;
      if (expect_q) exp_emit.push_back({ts, d, a, sel[15:0]});
   endtask

   task automatic do_space(input logic [15:0] exp, input string req);
      cmd = CMD_SPACE; tick(); cmd = CMD_NOP;
      chk(space_valid && space == exp, req, space, exp);
      tick();
      chk(!space_valid, "R7", space_valid, 0);
   endtask

   task automatic do_capture(input logic [31:0] d, input bit expect_kept);
      cap_valid = 1'b1; cap_data = d; tick(); cap_valid = 1'b0;
      if (expect_kept) exp_read.push_back({now_ts, d});
   endtask

   task automatic start_read(input logic [63:0] tmo);
      i_timeout = tmo; cmd = CMD_READ; tick(); cmd = CMD_NOP;
      chk(i_status == 4'b0100, "R8", i_status, 4'b0100);
   endtask

   task automatic expect_event(input string req);
      logic [95:0] e;
      e = exp_read.pop_front();
      chk(i_status == 4'b0000 && i_data == e[31:0] && i_ts == e[95:32], req,
          {i_status, i_ts, i_data}, {4'b0000, e});
   endtask

   // monitor: compares emitted events against the expected queue
   always @(negedge clk) begin
      if (rst_n && emit_valid) begin
         if (exp_emit.size() == 0) begin
            chk(1'b0, "R6 unexpected emission", {emit_ts, emit_data}, 0);
         end else begin
            logic [119:0] e;
            e = exp_emit.pop_front();
            chk({emit_ts, emit_data, emit_addr, emit_chan} == e, "R6 R2 emission",
                {emit_ts, emit_data, emit_addr, emit_chan}, e);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      tick();
      chk(o_status == 0 && i_status == 0 && !space_valid && !emit_valid, "reset",
          {o_status, i_status, space_valid, emit_valid}, 0);

      do_space(16'd4, "R7 empty");

      // R3 and R2: queue with destination bits set
      do_write(64'd200, 32'hA000_0001, 8'h03, 24'hAB_0005, 1'b1);
      chk(o_status == 3'b000, "R3", o_status, 0);
      chk_unreach();
      do_space(16'd3, "R7 one used");

      // R4: equal and earlier timestamps refused
      do_write(64'd100, 32'hDEAD_0001, 8'h01, 24'h00_0001, 1'b0);
      chk(o_status == 3'b010, "R4 equal", o_status, 3'b010);
      do_write(64'd50, 32'hDEAD_0002, 8'h01, 24'h00_0001, 1'b0);
      chk(o_status == 3'b010, "R4 earlier", o_status, 3'b010);

      // R1: no-operation leaves status, queues nothing
      o_ts = 64'd250; o_data = 32'hBAD0_0000; cmd = CMD_NOP;
      repeat (3) tick();
      chk(o_status == 3'b010, "R1 R4 held", o_status, 3'b010);

      do_write(64'd201, 32'hA000_0002, 8'h04, 24'h12_0007, 1'b1);
      chk(o_status == 3'b000, "R4 cleared R3", o_status, 0);
      do_write(64'd202, 32'hA000_0003, 8'h05, 24'h00_0008, 1'b1);
      do_write(64'd203, 32'hA000_0004, 8'h06, 24'h00_0009, 1'b1);
      do_space(16'd0, "R7 full");

      // R5: stall on full, stray write ignored
      do_write(64'd204, 32'hA000_0005, 8'h07, 24'h00_000A, 1'b1);
      chk(o_status == 3'b001, "R5 wait", o_status, 3'b001);
      do_write(64'd205, 32'hBAD0_0001, 8'h08, 24'h00_000B, 1'b0);
      chk(o_status == 3'b001, "R5 stray", o_status, 3'b001);
      do_space(16'd0, "R7 stalled");

      now_ts = 64'd200; tick();
      chk(o_status == 3'b001, "R5 still waiting", o_status, 3'b001);
      tick();
      chk(o_status == 3'b000, "R5 released", o_status, 0);

      now_ts = 64'd300;
      repeat (8) tick();
      chk(exp_emit.size() == 0, "R6 all emitted", exp_emit.size(), 0);
      do_space(16'd4, "R7 drained");

      // R9: captured events returned in order and held
      do_capture(32'hC000_0001, 1'b1);
      now_ts = 64'd301;
      do_capture(32'hC000_0002, 1'b1);
      start_read(64'd5000);
      tick();
      expect_event("R9 first");
      repeat (3) tick();
      chk(i_data == 32'hC000_0001 && i_ts == 64'd300, "R9 held", i_data, 32'hC000_0001);
      cmd = CMD_READ; tick(); cmd = CMD_NOP;
      chk(i_status == 4'b0100, "R8 second", i_status, 4'b0100);
      tick();
      expect_event("R9 second");

      // R10: timeout at, not before, the deadline
      now_ts = 64'd1000;
      start_read(64'd1003);
      now_ts = 64'd1002;
      cmd = CMD_READ; i_timeout = 64'd0;
      repeat (3) tick();
      cmd = CMD_NOP;
      chk(i_status == 4'b0100, "R8 R10 before deadline", i_status, 4'b0100);
      now_ts = 64'd1003; tick();
      chk(i_status == 4'b0001, "R10", i_status, 4'b0001);
      chk(i_data == 32'hC000_0002, "R9 held over timeout", i_data, 32'hC000_0002);
      chk_unreach();

      // R11: overflow reported alone, then normal data
      for (int k = 0; k < 5; k++) begin
         now_ts = 64'd1100 + 64'(k);
         do_capture(32'hE000_0000 + 32'(k), k < 4);
      end
      start_read(64'd9999);
      tick();
      chk(i_status == 4'b0010, "R11 overflow", i_status, 4'b0010);
      chk(i_data == 32'hC000_0002, "R11 no consume", i_data, 32'hC000_0002);
      start_read(64'd9999);
      tick();
      expect_event("R11 after clear");
      chk_unreach();

      repeat (3) tick();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule